// File: doc/BRIEF.md
# 8-bit PWM Timer with Fast and Phase-Correct Modes

This block is an 8-bit timer/counter with a single compare channel that drives one waveform pin. A prescaler divides the system clock and produces timer ticks, and the counter moves only on those ticks. In fast mode the count rises and wraps, giving a single-slope PWM. In phase-correct mode the count climbs to 255 and falls back to 0, which gives a symmetric dual-slope PWM with a period of 510 ticks.

The compare value is written into a shadow register. It moves into the active compare register only at the update point of the current mode, so every PWM period uses one compare value from start to end. A two-bit output-mode field selects one of four behaviours for the pin: disconnected, toggle on match, non-inverting or inverting. A compare flag and an overflow flag stay set until their clear strobes are pulsed. The extreme compare values 0 and 255 give defined results: a narrow spike, or an output that is constantly high or constantly low.

Top module: `pwm_timer8`

## Requirements
- R1: `presc_sel` sets the tick rate. Codes 1 to 7 select division by 1, 8, 32, 64, 128, 256 and 1024. Code 0 stops the counter. The counter changes only on ticks.
- R2: In fast mode (`mode_pc`=0) the count rises by one on each tick and wraps from 255 to 0. With `com`=1 the count wraps after it reaches the active compare value.
- R3: In phase-correct mode (`mode_pc`=1) the count runs 0 up to 255 and back down to 0. The value 255 lasts exactly one tick and is followed by 254. The count repeats every 510 ticks.
- R4: Fast mode with `com`=2 (non-inverting) sets the pin at the wrap and clears it on a compare match. If both happen on the same tick, the wrap wins. The pin is high for compare+1 of every 256 ticks: a one-tick spike for 0, and constantly high for 255.
- R5: Fast mode with `com`=3 (inverting) clears the pin at the wrap and sets it on a match, again with the wrap winning. The pin is high for 255−compare of every 256 ticks.
- R6: Fast mode with `com`=1 toggles the pin on each match. The pin has a period of 2×(compare+1) ticks at 50% duty, so compare 0 at division 1 gives half the clock rate.
- R7: Phase-correct mode with `com`=2 clears the pin on a match while counting up and sets it on a match while counting down. The pin is high for 2×compare of every 510 ticks: never high for 0, and always high for 255.
- R8: Phase-correct mode with `com`=3 is the inverse of R7. The pin is high for 510−2×compare ticks.
- R9: With `com`=0 in either mode, or `com`=1 in phase-correct mode, the pin is held low.
- R10: A write through `cmp_wr` loads only the shadow register. The shadow value becomes active at the wrap in fast mode, and on the tick where the count is 255 in phase-correct mode.
- R11: `cmp_flag` sets on every tick where the count equals the active compare value. `ovf_flag` sets at the wrap in fast mode, and on the tick where the count is 0 in phase-correct mode.
- R12: Each flag stays set until its clear strobe is high. If a set event and a clear fall in the same cycle, the flag ends up set.
- R13: A synchronous reset clears the count, both compare registers, both flags and the pin, and leaves the counter counting up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pc | input | 1 | 1 selects phase-correct mode, 0 selects fast mode |
| presc_sel | input | 3 | Prescaler code (0 stops the counter) |
| com | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverting, 3 inverting |
| cmp_wr | input | 1 | Write strobe for the shadow compare register |
| cmp_wdata | input | CW | Compare value to write |
| clr_cmp_flag | input | 1 | Clears the compare flag |
| clr_ovf_flag | input | 1 | Clears the overflow flag |
| wave_out | output | 1 | Waveform pin |
| count | output | CW | Current count |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two things can land in the same cycle: a flag-setting event and that flag's clear strobe. The bench holds both clear strobes high through a full period. It then counts the cycles in which each flag reads 1. A correct design shows a one-cycle pulse for each event, which is one pulse per fast period and two compare pulses per phase-correct period. If the clear took priority, the count would be zero. The wrap and the match also coincide at compare 255 and compare 0, and the constant-level vectors check how those collisions resolve.

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int CW  = 8,
  parameter int PSW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_pc,
  input  logic [2:0]    presc_sel,
  input  logic [1:0]    com,
  input  logic          cmp_wr,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          clr_cmp_flag,
  input  logic          clr_ovf_flag,
  output logic          wave_out,
  output logic [CW-1:0] count,
  output logic          cmp_flag,
  output logic          ovf_flag
);
  localparam logic [CW-1:0] TOPV = {CW{1'b1}};
  localparam logic [CW-1:0] BOTV = '0;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [PSW-1:0] pre_cnt, pre_lim;
  logic [CW-1:0]  ocr, ocr_buf, fast_top;
  logic           dir_up, out_q;
  logic           tick, match, fast_wrap, eff_up, upd_pt, pin_en, ovf_evt;

  // prescaler: terminal count per select code
  always_comb begin
    case (presc_sel)
      3'd2:    pre_lim = PSW'(7);
      3'd3:    pre_lim = PSW'(31);
      3'd4:    pre_lim = PSW'(63);
      3'd5:    pre_lim = PSW'(127);
      3'd6:    pre_lim = PSW'(255);
      3'd7:    pre_lim = PSW'(1023);
      default: pre_lim = '0;
    endcase
  end

  assign tick = (presc_sel != 3'd0) && (pre_cnt >= pre_lim);

  always_ff @(posedge clk) begin
    if (rst || presc_sel == 3'd0 || tick) pre_cnt <= '0;
    else                                  pre_cnt <= pre_cnt + 1'b1;
  end

  assign fast_top  = (com == 2'd1) ? ocr : TOPV;
  assign fast_wrap = count >= fast_top;
  assign match     = count == ocr;
  assign eff_up    = (count == BOTV) || (dir_up && count != TOPV);
  assign upd_pt    = mode_pc ? (count == TOPV) : fast_wrap;
  assign ovf_evt   = tick && (mode_pc ? (count == BOTV) : fast_wrap);
  assign pin_en    = com[1] || (com == 2'd1 && !mode_pc);
  assign wave_out  = out_q && pin_en;

  // counter and direction
  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (tick) begin
      if (!mode_pc) begin
        count  <= fast_wrap ? BOTV : count + ONE;
        dir_up <= 1'b1;
      end else if (eff_up) begin
        count  <= count + ONE;
        dir_up <= (count != TOPV - ONE);
      end else begin
        count  <= count - ONE;
        dir_up <= (count == BOTV + ONE);
      end
    end
  end

  // shadow and active compare
  always_ff @(posedge clk) begin
    if (rst) begin
      ocr     <= '0;
      ocr_buf <= '0;
    end else begin
      if (cmp_wr)         ocr_buf <= cmp_wdata;
      if (tick && upd_pt) ocr     <= ocr_buf;
    end
  end

  // waveform register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else if (tick) begin
      if (mode_pc) begin
        if (match && com == 2'd2)      out_q <= !eff_up;
        else if (match && com == 2'd3) out_q <= eff_up;
      end else begin
        case (com)
          2'd1: if (match) out_q <= !out_q;
          2'd2: if (fast_wrap) out_q <= 1'b1; else if (match) out_q <= 1'b0;
          2'd3: if (fast_wrap) out_q <= 1'b0; else if (match) out_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // sticky flags, set has priority over clear
  always_ff @(posedge clk) begin
    if (rst)                cmp_flag <= 1'b0;
    else if (tick && match) cmp_flag <= 1'b1;
    else if (clr_cmp_flag)  cmp_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)               ovf_flag <= 1'b0;
    else if (ovf_evt)      ovf_flag <= 1'b1;
    else if (clr_ovf_flag) ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_pc,
  input logic [2:0]    presc_sel,
  input logic [1:0]    com,
  input logic [CW-1:0] count,
  input logic          cmp_flag,
  input logic          ovf_flag,
  input logic          clr_cmp_flag,
  input logic          clr_ovf_flag
);
  localparam logic [CW-1:0] TOPV = {CW{1'b1}};

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    presc_sel == 3'd0 |=> $stable(count)); // R1

  AST_FAST_STEP: assert property (@(posedge clk) disable iff (rst)
    (!mode_pc && presc_sel == 3'd1 && com != 2'd1) |=> count == CW'($past(count) + 1'b1)); // R2

  AST_PC_TOP_TURN: assert property (@(posedge clk) disable iff (rst)
    (mode_pc && presc_sel == 3'd1 && count == TOPV) |=> count == TOPV - CW'(1)); // R3

  AST_CMP_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !clr_cmp_flag) |=> cmp_flag); // R12

  AST_OVF_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr_ovf_flag) |=> ovf_flag); // R12
endmodule

bind pwm_timer8 pwm_timer8_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mode_pc(mode_pc), .presc_sel(presc_sel), .com(com),
  .count(count), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
  .clr_cmp_flag(clr_cmp_flag), .clr_ovf_flag(clr_ovf_flag)
);

// File: tb/test_pwm_timer8.sv
`timescale 1ns/1ps
module test_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_pc = 1'b0;
  logic [2:0] presc_sel = 3'd1;
  logic [1:0] com = 2'd0;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = 8'd0;
  logic       clr_cmp_flag = 1'b0;
  logic       clr_ovf_flag = 1'b0;
  logic       wave_out, cmp_flag, ovf_flag;
  logic [7:0] count;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pwm_timer8 i_pwm_timer8 (
    .clk(clk), .rst(rst), .mode_pc(mode_pc), .presc_sel(presc_sel), .com(com),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .clr_cmp_flag(clr_cmp_flag),
    .clr_ovf_flag(clr_ovf_flag), .wave_out(wave_out), .count(count),
    .cmp_flag(cmp_flag), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic       pc;
    logic [1:0] cm;
    logic [7:0] cv;
    logic [9:0] win;
    logic [9:0] hi;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 8'd0,   10'd256, 10'd1},   // R4 spike
    '{1'b0, 2'd2, 8'd100, 10'd256, 10'd101}, // R4
    '{1'b0, 2'd2, 8'd255, 10'd256, 10'd256}, // R4 constant high
    '{1'b0, 2'd3, 8'd0,   10'd256, 10'd255}, // R5
    '{1'b0, 2'd3, 8'd100, 10'd256, 10'd155}, // R5
    '{1'b0, 2'd3, 8'd255, 10'd256, 10'd0},   // R5 constant low
    '{1'b1, 2'd2, 8'd0,   10'd510, 10'd0},   // R7 constant low
    '{1'b1, 2'd2, 8'd64,  10'd510, 10'd128}, // R7
    '{1'b1, 2'd2, 8'd255, 10'd510, 10'd510}, // R7 constant high
    '{1'b1, 2'd3, 8'd64,  10'd510, 10'd382}, // R8
    '{1'b1, 2'd3, 8'd255, 10'd510, 10'd0},   // R8
    '{1'b1, 2'd3, 8'd0,   10'd510, 10'd510}, // R8
    '{1'b0, 2'd1, 8'd0,   10'd2,   10'd1},   // R6 half clock
    '{1'b0, 2'd1, 8'd3,   10'd8,   10'd4},   // R6
    '{1'b0, 2'd1, 8'd9,   10'd20,  10'd10}   // R6
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic pc, input logic [1:0] cm, input logic [2:0] ps, input logic [7:0] cv);
    @(negedge clk);
    rst = 1'b1; mode_pc = pc; com = cm; presc_sel = ps;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; cmp_wr = 1'b1; cmp_wdata = cv;
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  task automatic count_high(input int win, output int hi);
    hi = 0;
    repeat (win) begin
      @(negedge clk);
      if (wave_out) hi++;
    end
  endtask

  function automatic string vec_req(input vec_t v);
    if (v.pc) return (v.cm == 2'd2) ? "R7" : "R8";
    if (v.cm == 2'd1) return "R6";
    return (v.cm == 2'd2) ? "R4" : "R5";
  endfunction

  task automatic wait_count(input int val, input bit need_up);
    int prev;
    prev = count;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (count == val && (!need_up || prev == val - 1)) break;
      prev = count;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi, c0, prev, bad, n255, n0, mx, nc, no;

    // R13 reset state
    repeat (3) @(negedge clk);
    check("R13 count at reset", count, 0);
    check("R13 flags at reset", {cmp_flag, ovf_flag}, 0);
    check("R13 pin at reset", wave_out, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      setup(VECS[i].pc, VECS[i].cm, 3'd1, VECS[i].cv);
      repeat (1100) @(negedge clk);
      count_high(int'(VECS[i].win), hi);
      check(vec_req(VECS[i]), hi, int'(VECS[i].hi));
    end

    // R2 fast up-count and wrap
    setup(1'b0, 2'd2, 3'd1, 8'd0);
    bad = 0; prev = count;
    repeat (600) begin
      @(negedge clk);
      if (count != 8'(prev + 1)) bad++;
      prev = count;
    end
    check("R2 fast step errors", bad, 0);
    setup(1'b0, 2'd1, 3'd1, 8'd3);
    repeat (20) @(negedge clk);
    mx = 0;
    repeat (40) begin @(negedge clk); if (count > mx) mx = count; end
    check("R2 toggle-mode top", mx, 3);

    // R3 dual-slope sequence
    setup(1'b1, 2'd2, 3'd1, 8'd64);
    repeat (600) @(negedge clk);
    bad = 0; n255 = 0; n0 = 0; prev = count;
    repeat (510) begin
      @(negedge clk);
      if (prev == 255 && count != 254) bad++;
      if (count == 255) n255++;
      if (count == 0) n0++;
      prev = count;
    end
    check("R3 top after-value errors", bad, 0);
    check("R3 cycles at 255", n255, 1);
    check("R3 cycles at 0", n0, 1);
    c0 = count;
    repeat (510) @(negedge clk);
    check("R3 period 510", count, c0);

    // R1 prescaler
    setup(1'b0, 2'd2, 3'd2, 8'd0);
    repeat (13) @(negedge clk);
    c0 = count;
    repeat (160) @(negedge clk);
    check("R1 divide by 8", 8'(count - c0), 20);
    setup(1'b0, 2'd2, 3'd7, 8'd0);
    repeat (5) @(negedge clk);
    c0 = count;
    repeat (2048) @(negedge clk);
    check("R1 divide by 1024", 8'(count - c0), 2);
    setup(1'b0, 2'd2, 3'd0, 8'd0);
    repeat (50) @(negedge clk);
    check("R1 stopped", count, 0);

    // R9 pin held low
    setup(1'b0, 2'd0, 3'd1, 8'd100);
    repeat (600) @(negedge clk);
    count_high(256, hi);
    check("R9 com 0 fast", hi, 0);
    setup(1'b1, 2'd1, 3'd1, 8'd100);
    repeat (600) @(negedge clk);
    count_high(510, hi);
    check("R9 com 1 phase-correct", hi, 0);

    // R10 double buffering
    setup(1'b1, 2'd2, 3'd1, 8'd64);
    repeat (1100) @(negedge clk);
    wait_count(10, 1'b1);
    cmp_wr = 1'b1; cmp_wdata = 8'd200;
    @(negedge clk);
    cmp_wr = 1'b0;
    wait_count(100, 1'b1);
    check("R10 old compare still active", wave_out, 0);
    repeat (1100) @(negedge clk);
    count_high(510, hi);
    check("R10 new compare after top", hi, 400);

    // R11/R12 set and clear in the same cycle
    clr_cmp_flag = 1'b1; clr_ovf_flag = 1'b1;
    setup(1'b0, 2'd2, 3'd1, 8'd100);
    repeat (600) @(negedge clk);
    nc = 0; no = 0;
    repeat (256) begin @(negedge clk); if (cmp_flag) nc++; if (ovf_flag) no++; end
    check("R12 fast cmp pulses with clear held", nc, 1);
    check("R11 fast ovf pulses", no, 1);
    setup(1'b1, 2'd2, 3'd1, 8'd64);
    repeat (600) @(negedge clk);
    nc = 0; no = 0;
    repeat (510) begin @(negedge clk); if (cmp_flag) nc++; if (ovf_flag) no++; end
    check("R11 phase-correct cmp pulses", nc, 2);
    check("R11 phase-correct ovf pulses", no, 1);

    // R12 sticky and cleared
    clr_cmp_flag = 1'b0; clr_ovf_flag = 1'b0;
    repeat (600) @(negedge clk);
    check("R12 cmp flag sticky", cmp_flag, 1);
    check("R12 ovf flag sticky", ovf_flag, 1);
    wait_count(130, 1'b0);
    clr_cmp_flag = 1'b1;
    @(negedge clk);
    clr_cmp_flag = 1'b0;
    check("R12 cmp flag cleared", cmp_flag, 0);

    // R13 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R13 count after reset", count, 0);
    check("R13 flags after reset", {cmp_flag, ovf_flag}, 0);
    check("R13 pin after reset", wave_out, 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule